// File: doc/BRIEF.md
# Redundant Controller Failover Arbiter

This block decides which of two redundant control processors drives the plant: a primary unit and a hot-standby backup. It takes plain health flags for each unit (primary alive, primary I/O card count agreement with the configured count, and per-messenger commissioned and communicating vectors for both units) and a phase input that marks startup or steady state. It enables the outputs of exactly one unit at a time.

When the primary becomes unfit, control throws over to the backup. Control throws back once the primary is fully healthy again. Every handover passes through a blocking window of `XFER_CYCLES` clock cycles in which neither unit may drive contacts or breaker commands. Per-unit active bits and four one-cycle event strobes let the surrounding logic log each handover. All pins are plain control and status signals. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `failover_ctrl`

## Requirements
- R1: After reset, `pri_out_en` and `pri_active` are 1, `bak_out_en` and `bak_active` are 0, and all four event strobes are 0.
- R2: `pri_out_en` and `bak_out_en` are never both 1. A unit that is not active has its output enable at 0.
- R3: While the primary holds control, `pri_alive`=0 or `pri_io_match`=0 starts a throw-over to the backup, whatever the phase.
- R4: With `steady`=0 (startup), any installed messenger whose bit in `pri_cmsn` or `pri_comm` is 0 starts a throw-over.
- R5: With `steady`=1, losing some installed messengers on the primary starts a throw-over only if every installed messenger has both its `bak_cmsn` and `bak_comm` bits at 1. Otherwise the primary keeps control.
- R6: With `steady`=1, if the primary loses every installed messenger (and at least one is installed), a throw-over starts whatever the backup's health.
- R7: While the backup holds control, a throwback starts only when `pri_alive`, `pri_io_match` and all installed messenger bits of `pri_cmsn & pri_comm` are 1 together.
- R8: A handover keeps both output enables at 0 for exactly `XFER_CYCLES` cycles, starting the cycle after the deciding clock edge. Health inputs are not examined during that window.
- R9: `pri_active` is 1 exactly while the primary's outputs are enabled, and `bak_active` is 1 exactly while the backup's outputs are enabled.
- R10: The relinquish strobe of the outgoing unit is 1 for the single first cycle of the window. The assume strobe of the incoming unit is 1 for the single first cycle in which its output enable is 1.
- R11: Messengers whose `inst_mask` bit is 0 are ignored in every throw-over and throwback decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| steady | input | 1 | 1 = steady state, 0 = startup phase |
| pri_alive | input | 1 | Primary unit is running |
| pri_io_match | input | 1 | Primary's I/O card count equals the configured count |
| inst_mask | input | N_MSG | 1 = messenger installed |
| pri_cmsn | input | N_MSG | Messenger commissioned in primary |
| pri_comm | input | N_MSG | Messenger communicating with primary |
| bak_cmsn | input | N_MSG | Messenger commissioned in backup |
| bak_comm | input | N_MSG | Messenger communicating with backup |
| pri_out_en | output | 1 | Primary contact/breaker outputs enabled |
| bak_out_en | output | 1 | Backup contact/breaker outputs enabled |
| pri_active | output | 1 | Primary active status |
| bak_active | output | 1 | Backup active status |
| ev_pri_assume | output | 1 | Primary assumes control strobe |
| ev_bak_assume | output | 1 | Backup assumes control strobe |
| ev_pri_relinq | output | 1 | Primary relinquishes control strobe |
| ev_bak_relinq | output | 1 | Backup relinquishes control strobe |

## Verification
The bench builds the block with `N_MSG`=4 and `XFER_CYCLES`=5. With these values the whole blocking window and its edges fall within a few cycles, so each handover can be compared cycle by cycle against a behavioural model. Four messengers are enough to leave one uninstalled while the others cover partial loss, total loss and a backup that is missing exactly one messenger. The default window length, about 150 ms at the clock rate, only changes the counter limit.

// File: rtl/fo_pkg.sv
package fo_pkg;
  typedef enum logic [1:0] {
    S_PRI  = 2'd0,
    S_TOB  = 2'd1,
    S_BAK  = 2'd2,
    S_TOP  = 2'd3
  } fo_state_e;
endpackage

// File: rtl/fo_health.sv
module fo_health #(
  parameter int N_MSG = 4
) (
  input  logic             steady,
  input  logic             pri_alive,
  input  logic             pri_io_match,
  input  logic [N_MSG-1:0] inst_mask,
  input  logic [N_MSG-1:0] pri_cmsn,
  input  logic [N_MSG-1:0] pri_comm,
  input  logic [N_MSG-1:0] bak_cmsn,
  input  logic [N_MSG-1:0] bak_comm,
  output logic             go_over,
  output logic             go_back
);
  logic [N_MSG-1:0] pri_lost, bak_lost;
  logic any_inst, pri_some, pri_all, bak_full, base_fault;

  always_comb begin
    pri_lost   = inst_mask & ~(pri_cmsn & pri_comm);
    bak_lost   = inst_mask & ~(bak_cmsn & bak_comm);
    any_inst   = |inst_mask;
    pri_some   = |pri_lost;
    pri_all    = any_inst && (pri_lost == inst_mask);
    bak_full   = ~|bak_lost;
    base_fault = !pri_alive || !pri_io_match;
    go_over    = base_fault
              || (!steady && pri_some)
              || (steady && pri_some && bak_full)
              || (steady && pri_all);
    go_back    = pri_alive && pri_io_match && !pri_some;
  end
endmodule

// File: rtl/fo_timer.sv
module fo_timer #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LOADV = CW'(LEN - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOADV;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  p_timer_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == LOADV));
endmodule

// File: rtl/failover_ctrl.sv
module failover_ctrl
  import fo_pkg::*;
#(
  parameter int N_MSG       = 4,
  parameter int XFER_CYCLES = 37_500_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             steady,
  input  logic             pri_alive,
  input  logic             pri_io_match,
  input  logic [N_MSG-1:0] inst_mask,
  input  logic [N_MSG-1:0] pri_cmsn,
  input  logic [N_MSG-1:0] pri_comm,
  input  logic [N_MSG-1:0] bak_cmsn,
  input  logic [N_MSG-1:0] bak_comm,
  output logic             pri_out_en,
  output logic             bak_out_en,
  output logic             pri_active,
  output logic             bak_active,
  output logic             ev_pri_assume,
  output logic             ev_bak_assume,
  output logic             ev_pri_relinq,
  output logic             ev_bak_relinq
);
  fo_state_e state, state_nx;
  logic go_over, go_back, win_start, win_done;

  fo_health #(.N_MSG(N_MSG)) u_health (
    .steady(steady), .pri_alive(pri_alive), .pri_io_match(pri_io_match),
    .inst_mask(inst_mask), .pri_cmsn(pri_cmsn), .pri_comm(pri_comm),
    .bak_cmsn(bak_cmsn), .bak_comm(bak_comm),
    .go_over(go_over), .go_back(go_back)
  );

  fo_timer #(.LEN(XFER_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(win_start), .expired(win_done)
  );

  always_comb begin
    state_nx = state;
    case (state)
      S_PRI: if (go_over)  state_nx = S_TOB;
      S_TOB: if (win_done) state_nx = S_BAK;
      S_BAK: if (go_back)  state_nx = S_TOP;
      S_TOP: if (win_done) state_nx = S_PRI;
      default:             state_nx = S_PRI;
    endcase
    win_start = (state == S_PRI && state_nx == S_TOB)
             || (state == S_BAK && state_nx == S_TOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_PRI;
      ev_pri_assume <= 1'b0;
      ev_bak_assume <= 1'b0;
      ev_pri_relinq <= 1'b0;
      ev_bak_relinq <= 1'b0;
    end else begin
      state         <= state_nx;
      ev_pri_relinq <= (state == S_PRI) && (state_nx == S_TOB);
      ev_bak_relinq <= (state == S_BAK) && (state_nx == S_TOP);
      ev_bak_assume <= (state == S_TOB) && (state_nx == S_BAK);
      ev_pri_assume <= (state == S_TOP) && (state_nx == S_PRI);
    end
  end

  assign pri_active = (state == S_PRI);
  assign bak_active = (state == S_BAK);
  assign pri_out_en = pri_active;
  assign bak_out_en = bak_active;

  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_out_en && bak_out_en));
  p_relinq_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pri_relinq || ev_bak_relinq) |-> (!pri_out_en && !bak_out_en));
  p_assume_bak_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bak_assume |-> (bak_out_en && $rose(bak_out_en)));
  p_assume_pri_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pri_assume |-> pri_out_en);
  p_strobe_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pri_relinq || ev_bak_relinq || ev_pri_assume || ev_bak_assume) |=>
      !(ev_pri_relinq || ev_bak_relinq || ev_pri_assume || ev_bak_assume));
  p_fall_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_out_en) |-> !bak_out_en);
  p_active_ties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bak_active) |-> $past(!pri_active));
endmodule

// File: tb/tb_failover_ctrl.sv
module tb_failover_ctrl;
  localparam int N = 4;
  localparam int LEN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic steady, pri_alive, pri_io_match;
  logic [N-1:0] inst_mask, pri_cmsn, pri_comm, bak_cmsn, bak_comm;
  logic pri_out_en, bak_out_en, pri_active, bak_active;
  logic ev_pri_assume, ev_bak_assume, ev_pri_relinq, ev_bak_relinq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  failover_ctrl #(.N_MSG(N), .XFER_CYCLES(LEN)) dut (
    .clk(clk), .rst_n(rst_n), .steady(steady), .pri_alive(pri_alive),
    .pri_io_match(pri_io_match), .inst_mask(inst_mask), .pri_cmsn(pri_cmsn),
    .pri_comm(pri_comm), .bak_cmsn(bak_cmsn), .bak_comm(bak_comm),
    .pri_out_en(pri_out_en), .bak_out_en(bak_out_en), .pri_active(pri_active),
    .bak_active(bak_active), .ev_pri_assume(ev_pri_assume),
    .ev_bak_assume(ev_bak_assume), .ev_pri_relinq(ev_pri_relinq),
    .ev_bak_relinq(ev_bak_relinq)
  );

  // behavioural reference: owner 0=primary 1=backup, win = cycles left blocked
  int owner = 0, win = 0;
  bit m_pa, m_ba, m_pr, m_br;

  function automatic bit over_now();
    logic [N-1:0] pl, bl;
    pl = inst_mask & ~(pri_cmsn & pri_comm);
    bl = inst_mask & ~(bak_cmsn & bak_comm);
    if (!pri_alive || !pri_io_match) return 1;
    if (!steady) return (pl != 0);
    if (pl != 0 && bl == 0) return 1;
    return (inst_mask != 0 && pl == inst_mask);
  endfunction

  function automatic bit back_now();
    return pri_alive && pri_io_match && ((inst_mask & ~(pri_cmsn & pri_comm)) == 0);
  endfunction

  always @(posedge clk) begin
    m_pa = 0; m_ba = 0; m_pr = 0; m_br = 0;
    if (!rst_n) begin
      owner = 0; win = 0;
    end else if (win > 0) begin
      win = win - 1;
      if (win == 0) begin
        if (owner == 1) m_ba = 1; else m_pa = 1;
      end
    end else if (owner == 0 && over_now()) begin
      owner = 1; win = LEN; m_pr = 1;
    end else if (owner == 1 && back_now()) begin
      owner = 0; win = LEN; m_br = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      chk(pri_out_en == (owner == 0 && win == 0), "R8 pri_out_en", pri_out_en, owner == 0 && win == 0);
      chk(bak_out_en == (owner == 1 && win == 0), "R8 bak_out_en", bak_out_en, owner == 1 && win == 0);
      chk(pri_active == pri_out_en && bak_active == bak_out_en, "R9 active",
          {pri_active, bak_active}, {pri_out_en, bak_out_en});
      chk(!(pri_out_en && bak_out_en), "R2 exclusive", pri_out_en + bak_out_en, 1);
      chk({ev_pri_assume, ev_bak_assume, ev_pri_relinq, ev_bak_relinq} == {m_pa, m_ba, m_pr, m_br},
          "R10 strobes", {ev_pri_assume, ev_bak_assume, ev_pri_relinq, ev_bak_relinq},
          {m_pa, m_ba, m_pr, m_br});
    end
    if (cyc > 20000 && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic healthy();
    steady = 0; pri_alive = 1; pri_io_match = 1;
    inst_mask = 4'b0111;
    pri_cmsn = 4'b0111; pri_comm = 4'b0111;
    bak_cmsn = 4'b0111; bak_comm = 4'b0111;
  endtask

  initial begin
    healthy();
    step(3);
    rst_n = 1;
    // R1 reset state (sampled before the first active edge after reset release)
    chk(pri_out_en && pri_active && !bak_out_en && !bak_active, "R1 reset owner",
        {pri_out_en, pri_active, bak_out_en, bak_active}, 4'b1100);
    chk({ev_pri_assume, ev_bak_assume, ev_pri_relinq, ev_bak_relinq} == 0, "R1 strobes", 0, 0);
    step(4);
    // R11: uninstalled bit 3 lost everywhere, still primary
    chk(pri_active, "R11 uninstalled ignored", pri_active, 1);

    // R3: I/O card count mismatch
    pri_io_match = 0;
    step(LEN + 3);
    chk(bak_active, "R3 io mismatch throw-over", bak_active, 1);
    // R7: partial health is not enough
    pri_io_match = 1; pri_comm = 4'b0101;
    step(LEN + 3);
    chk(bak_active, "R7 no throwback while messenger lost", bak_active, 1);
    pri_comm = 4'b0111; pri_alive = 0;
    step(4);
    chk(bak_active, "R7 no throwback while primary down", bak_active, 1);
    pri_alive = 1;
    step(LEN + 3);
    chk(pri_active, "R7 throwback on full health", pri_active, 1);

    // R4: startup messenger loss
    pri_cmsn = 4'b0110;
    step(LEN + 3);
    chk(bak_active, "R4 startup loss throw-over", bak_active, 1);
    healthy();
    step(LEN + 3);
    chk(pri_active, "R7 return after R4", pri_active, 1);

    // R5: steady partial loss, backup missing one messenger -> stay
    steady = 1; bak_comm = 4'b0011; pri_comm = 4'b0101;
    step(LEN + 3);
    chk(pri_active, "R5 stays when backup incomplete", pri_active, 1);
    bak_comm = 4'b1111;
    step(LEN + 3);
    chk(bak_active, "R5 throw-over when backup complete", bak_active, 1);
    healthy(); steady = 1;
    step(LEN + 3);
    chk(pri_active, "R7 return after R5", pri_active, 1);

    // R6: steady total loss, backup broken
    bak_cmsn = 4'b0000; pri_comm = 4'b1000;
    step(LEN + 3);
    chk(bak_active, "R6 total loss throw-over", bak_active, 1);
    healthy();
    step(LEN + 3);
    chk(pri_active, "R7 return after R6", pri_active, 1);

    // R11: no messengers installed, steady, all lost -> no throw-over
    steady = 1; inst_mask = 4'b0000; pri_cmsn = 0; pri_comm = 0; bak_cmsn = 0;
    step(LEN + 3);
    chk(pri_active, "R11 none installed ignored", pri_active, 1);

    // R3: primary down
    healthy(); pri_alive = 0;
    step(LEN + 3);
    chk(bak_active, "R3 primary down throw-over", bak_active, 1);
    healthy();
    step(LEN + 3);
    chk(pri_active, "R7 final return", pri_active, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule